// File: doc/BRIEF.md
# System Reset Controller

This block drives the system-wide reset and a second reset for the memory controller. It has two sources of reset. The first is an active-low power-on input, which must stay low for a minimum number of system clocks before it counts as a reset. The second is a software request, written as a 1 into bit 0 of a 32-bit control/status register. Each source gives its own pulse length. The pulse lengths are counted partly in system clocks and partly in rising edges of a slower, unrelated reference clock. The register also records which source caused the last reset, and it holds a sticky flag for a watchdog indication from the processor. That flag is kept for software to read and never causes a reset.

The power-on, watchdog and reference-clock inputs pass through synchronizers into the system clock domain. The reset outputs are flip-flops clocked by the system clock, so they always release on a rising system clock edge. Every pulse-length constant is a parameter. A fast simulation can shrink the long power-on stretch, which by default is roughly 200 ms.

Top module: `sysrst_ctrl`

## Requirements
- R1: A low level on `por_n` is accepted as a power-on reset only once it has been seen for `POR_MIN_CYC` (default 15) consecutive system clocks after synchronization. A shorter low pulse changes neither output nor any register bit.
- R2: After a power-on reset is accepted, `sys_rst_n` stays low while `por_n` is low. It then stays low for `POR_EXT_TICKS` further rising edges of `ref_clk` after `por_n` returns high.
- R3: Writing a word with bit 0 set while `sys_rst_n` is high starts a software reset. Bit 0 always reads 0.
- R4: Bit 1 of the register is the software-reset cause flag. It is set by a software reset, cleared by a power-on reset, and not changed by writes.
- R5: Bit 2 is the watchdog flag. It becomes 1 while `wd_n` is low. It is cleared by a power-on reset, by a software reset, or by a write with bit 2 equal to 0. A write with bit 2 equal to 1 leaves it unchanged, and `wd_n` never asserts either reset output.
- R6: Bits 31 to 3 always read 0, and the values written to them have no effect.
- R7: During a power-on reset, `mem_rst_n` follows `sys_rst_n`. During a software reset, `mem_rst_n` is low for exactly `MEM_SW_CYC` (default 4) system clocks, starting in the same cycle as `sys_rst_n`.
- R8: A software reset holds `sys_rst_n` low through three phases in order: `SW_PRE_CYC` system clocks, then `SW_REF_TICKS` reference edges, then `SW_TAIL_CYC` system clocks. No reset of either source lasts fewer than `MIN_CYC` (default 512) system clocks. When the minimum dominates, a software reset holds `sys_rst_n` low for exactly `MIN_CYC` cycles.
- R9: `sys_rst_n` rises only at a rising edge of `clk`.
- R10: Register writes made while `sys_rst_n` is low are ignored. A second software request does not lengthen the pulse.
- R11: After a power-on reset the register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| ref_clk | input | 1 | Slow reference clock, asynchronous to `clk` |
| por_n | input | 1 | Power-on reset request, active low, asynchronous |
| wd_n | input | 1 | Watchdog indication from the processor, active low, asynchronous |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Register contents: bit 2 watchdog flag, bit 1 software-reset flag, all other bits 0 |
| sys_rst_n | output | 1 | System reset, active low, registered |
| mem_rst_n | output | 1 | Memory-controller reset, active low, registered |

## Verification
The bench measures pulse widths to the exact cycle, because an off-by-one error in the minimum-length hold or in the memory-reset window only shows up as one cycle too many or too few. It sends a power-on glitch shorter than the qualification window while both flags are set. A filter that is missing or too short would reset the system and wipe the flags. Random register writes are mixed with watchdog pulses to catch a write of 1 that wrongly clears the watchdog flag, or reserved bits that leak into the read value. It also writes a second software request partway through a reset, which a design that accepts writes while busy would turn into a longer pulse.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

  localparam int unsigned CSR_W = 32;

  // control/status register bit positions (decoded by software)
  localparam int unsigned BIT_SWR = 0;  // software reset trigger, write-only
  localparam int unsigned BIT_SWS = 1;  // software reset cause flag
  localparam int unsigned BIT_WDF = 2;  // watchdog flag

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_POR_WAIT = 3'd1,
    ST_POR_EXT  = 3'd2,
    ST_SW_PRE   = 3'd3,
    ST_SW_REF   = 3'd4,
    ST_SW_TAIL  = 3'd5,
    ST_HOLD     = 3'd6
  } seq_state_e;

endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          INIT   = 1'b0
) (
  input  logic clk,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain = {STAGES{INIT}};

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) chain <= d;
    end else begin : g_multi
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sysrst_por_filter.sv
module sysrst_por_filter #(
  parameter int unsigned MIN_CYC = 15
) (
  input  logic clk,
  input  logic act,
  output logic hit
);

  // history of the synchronized request; accepted only when every slot is set
  logic [MIN_CYC-1:0] hist = '0;

  always_ff @(posedge clk) hist <= {hist[MIN_CYC-2:0], act};

  assign hit = &hist;

endmodule

// File: rtl/sysrst_csr.sv
module sysrst_csr
  import sysrst_pkg::*;
(
  input  logic             clk,
  input  logic             por_hit,
  input  logic             idle,
  input  logic             wd_act,
  input  logic             wr,
  input  logic [CSR_W-1:0] wdata,
  output logic [CSR_W-1:0] rdata,
  output logic             sw_req
);

  logic sw_q = 1'b0;
  logic wd_q = 1'b0;
  logic sw_d, wd_d, wr_ok;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[CSR_W-1:BIT_WDF+1], wdata[BIT_SWS]};

  assign wr_ok  = wr & idle;
  assign sw_req = wr_ok & wdata[BIT_SWR];

  always_comb begin
    sw_d = sw_q;
    if (por_hit)     sw_d = 1'b0;
    else if (sw_req) sw_d = 1'b1;
  end

  always_comb begin
    wd_d = wd_q;
    if (por_hit)                         wd_d = 1'b0;
    else if (sw_req)                     wd_d = 1'b0;
    else if (wd_act)                     wd_d = 1'b1;
    else if (wr_ok && !wdata[BIT_WDF])   wd_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    sw_q <= sw_d;
    wd_q <= wd_d;
  end

  always_comb begin
    rdata          = '0;
    rdata[BIT_SWS] = sw_q;
    rdata[BIT_WDF] = wd_q;
  end

  // R4: a software request marks the cause flag
  p_sw_sets_cause_r4: assert property (@(posedge clk) disable iff (por_hit)
    (sw_req && !por_hit) |=> sw_q);

  // R10: while a reset runs, the cause flag cannot move except by power-on
  p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (por_hit)
    (!idle && !por_hit) |=> $stable(sw_q));

  // R5: watchdog input sets the flag
  p_wd_sets_flag_r5: assert property (@(posedge clk) disable iff (por_hit)
    (wd_act && !por_hit && !sw_req) |=> wd_q);

  // R5: a write of zero to the flag clears it when the input is quiet
  p_wd_write_clear_r5: assert property (@(posedge clk) disable iff (por_hit)
    (wr && idle && !wdata[BIT_WDF] && !wd_act && !por_hit && !sw_req) |=> !wd_q);

endmodule

// File: rtl/sysrst_seq.sv
module sysrst_seq
  import sysrst_pkg::*;
#(
  parameter int unsigned POR_EXT_TICKS = 2000000,
  parameter int unsigned SW_PRE_CYC    = 66,
  parameter int unsigned SW_REF_TICKS  = 2,
  parameter int unsigned SW_TAIL_CYC   = 1600,
  parameter int unsigned MIN_CYC       = 512,
  parameter int unsigned MEM_SW_CYC    = 4
) (
  input  logic clk,
  input  logic por_hit,
  input  logic por_act,
  input  logic ref_tick,
  input  logic sw_req,
  output logic sys_rst_n,
  output logic mem_rst_n
);

  localparam int unsigned SEG_AB  = (POR_EXT_TICKS > SW_PRE_CYC) ? POR_EXT_TICKS : SW_PRE_CYC;
  localparam int unsigned SEG_CD  = (SW_REF_TICKS > SW_TAIL_CYC) ? SW_REF_TICKS : SW_TAIL_CYC;
  localparam int unsigned SEG_MAX = (SEG_AB > SEG_CD) ? SEG_AB : SEG_CD;
  localparam int unsigned SEG_W   = $clog2(SEG_MAX + 1);
  localparam int unsigned TOT_W   = $clog2(MIN_CYC + 1);

  seq_state_e       st_q  = ST_POR_WAIT;
  seq_state_e       st_d;
  logic [SEG_W-1:0] seg_q = '0;
  logic [SEG_W-1:0] seg_d;
  logic [TOT_W-1:0] tot_q = '0;
  logic [TOT_W-1:0] tot_d;
  logic             src_q = 1'b1;  // 1: power-on sequence, 0: software sequence
  logic             src_d;
  logic             sys_n_q = 1'b0;
  logic             mem_n_q = 1'b0;

  always_comb begin
    st_d  = st_q;
    seg_d = seg_q;
    src_d = src_q;
    if (st_q == ST_IDLE || tot_q == TOT_W'(MIN_CYC)) tot_d = tot_q;
    else                                             tot_d = tot_q + 1'b1;

    if (por_hit) begin
      st_d  = ST_POR_WAIT;
      seg_d = '0;
      tot_d = '0;
      src_d = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (sw_req) begin
            st_d  = ST_SW_PRE;
            seg_d = '0;
            tot_d = '0;
            src_d = 1'b0;
          end
        end
        ST_POR_WAIT: begin
          if (!por_act) begin
            st_d  = ST_POR_EXT;
            seg_d = '0;
          end
        end
        ST_POR_EXT: begin
          if (por_act) begin
            st_d  = ST_POR_WAIT;
            seg_d = '0;
          end else if (ref_tick) begin
            if (seg_q == SEG_W'(POR_EXT_TICKS - 1)) begin
              st_d  = ST_HOLD;
              seg_d = '0;
            end else begin
              seg_d = seg_q + 1'b1;
            end
          end
        end
        ST_SW_PRE: begin
          if (seg_q == SEG_W'(SW_PRE_CYC - 1)) begin
            st_d  = ST_SW_REF;
            seg_d = '0;
          end else begin
            seg_d = seg_q + 1'b1;
          end
        end
        ST_SW_REF: begin
          if (ref_tick) begin
            if (seg_q == SEG_W'(SW_REF_TICKS - 1)) begin
              st_d  = ST_SW_TAIL;
              seg_d = '0;
            end else begin
              seg_d = seg_q + 1'b1;
            end
          end
        end
        ST_SW_TAIL: begin
          if (seg_q == SEG_W'(SW_TAIL_CYC - 1)) begin
            st_d  = ST_HOLD;
            seg_d = '0;
          end else begin
            seg_d = seg_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (src_q && por_act)                  st_d = ST_POR_WAIT;
          else if (tot_q >= TOT_W'(MIN_CYC - 1)) st_d = ST_IDLE;
        end
        default: st_d = ST_POR_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    st_q    <= st_d;
    seg_q   <= seg_d;
    tot_q   <= tot_d;
    src_q   <= src_d;
    sys_n_q <= (st_d == ST_IDLE);
    mem_n_q <= !((st_d != ST_IDLE) && (src_d || (tot_d < TOT_W'(MEM_SW_CYC))));
  end

  assign sys_rst_n = sys_n_q;
  assign mem_rst_n = mem_n_q;

  // R7: the memory-controller reset is never active on its own
  p_mem_within_sys_r7: assert property (@(posedge clk) disable iff (por_hit)
    !mem_n_q |-> !sys_n_q);

  // R8: every release comes after the full minimum hold
  p_min_pulse_r8: assert property (@(posedge clk) disable iff (por_hit)
    $rose(sys_n_q) |-> (tot_q == TOT_W'(MIN_CYC)));

  // R2: a power-on sequence never releases while the request is present
  p_por_release_r2: assert property (@(posedge clk) disable iff (por_hit)
    ($rose(sys_n_q) && src_q) |-> !$past(por_act));

  // R3: a software request starts a reset on the next cycle
  p_sw_starts_r3: assert property (@(posedge clk) disable iff (por_hit)
    (sw_req && !por_hit) |=> (!sys_n_q && !mem_n_q));

endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
  import sysrst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned POR_MIN_CYC   = 15,
  parameter int unsigned POR_EXT_TICKS = 2000000,
  parameter int unsigned SW_PRE_CYC    = 66,
  parameter int unsigned SW_REF_TICKS  = 2,
  parameter int unsigned SW_TAIL_CYC   = 1600,
  parameter int unsigned MIN_CYC       = 512,
  parameter int unsigned MEM_SW_CYC    = 4
) (
  input  logic        clk,
  input  logic        ref_clk,
  input  logic        por_n,
  input  logic        wd_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sys_rst_n,
  output logic        mem_rst_n
);

  logic por_act, por_hit, wd_act, ref_s, ref_tick, sw_req;
  logic ref_prev = 1'b0;

  sysrst_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_por (
    .clk(clk), .d(~por_n), .q(por_act)
  );

  sysrst_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_wd (
    .clk(clk), .d(~wd_n), .q(wd_act)
  );

  sysrst_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_ref (
    .clk(clk), .d(ref_clk), .q(ref_s)
  );

  always_ff @(posedge clk) ref_prev <= ref_s;
  assign ref_tick = ref_s & ~ref_prev;

  sysrst_por_filter #(.MIN_CYC(POR_MIN_CYC)) u_filter (
    .clk(clk), .act(por_act), .hit(por_hit)
  );

  sysrst_seq #(
    .POR_EXT_TICKS(POR_EXT_TICKS),
    .SW_PRE_CYC   (SW_PRE_CYC),
    .SW_REF_TICKS (SW_REF_TICKS),
    .SW_TAIL_CYC  (SW_TAIL_CYC),
    .MIN_CYC      (MIN_CYC),
    .MEM_SW_CYC   (MEM_SW_CYC)
  ) u_seq (
    .clk      (clk),
    .por_hit  (por_hit),
    .por_act  (por_act),
    .ref_tick (ref_tick),
    .sw_req   (sw_req),
    .sys_rst_n(sys_rst_n),
    .mem_rst_n(mem_rst_n)
  );

  sysrst_csr u_csr (
    .clk    (clk),
    .por_hit(por_hit),
    .idle   (sys_rst_n),
    .wd_act (wd_act),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .sw_req (sw_req)
  );

  // R5: a watchdog indication alone never pulls the system into reset
  p_wd_no_reset_r5: assert property (@(posedge clk) disable iff (por_hit)
    (sys_rst_n && !sw_req && !por_hit && wd_act) |=> sys_rst_n);

endmodule

// File: tb/sysrst_ctrl_tb.sv
module sysrst_ctrl_tb;

  localparam int unsigned EXT_TICKS = 200;
  localparam int unsigned PRE_CYC   = 66;
  localparam int unsigned REF_TICKS = 2;
  localparam int unsigned TAIL_CYC  = 10;
  localparam int unsigned MIN_C     = 128;
  localparam int unsigned MEM_C     = 4;
  localparam int unsigned REF_RATIO = 5;  // clk cycles per ref_clk period

  logic        clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        por_n = 1'b0;
  logic        wd_n = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sys_rst_n, mem_rst_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit wd_exp  = 1'b0;
  bit sw_exp  = 1'b0;

  sysrst_ctrl #(
    .POR_EXT_TICKS(EXT_TICKS), .SW_PRE_CYC(PRE_CYC), .SW_REF_TICKS(REF_TICKS),
    .SW_TAIL_CYC(TAIL_CYC), .MIN_CYC(MIN_C), .MEM_SW_CYC(MEM_C)
  ) u_dut (
    .clk(clk), .ref_clk(ref_clk), .por_n(por_n), .wd_n(wd_n),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst_n(sys_rst_n), .mem_rst_n(mem_rst_n)
  );

  always #10 clk = ~clk;
  initial begin
    #3;
    forever #50 ref_clk = ~ref_clk;
  end

  function automatic logic [31:0] exp_reg(input bit wd, input bit sw);
    return {29'b0, wd, sw, 1'b0};
  endfunction

  function automatic int exp_sw_len();
    int phases = PRE_CYC + REF_TICKS * REF_RATIO + TAIL_CYC + 1;
    return (phases > MIN_C) ? -1 : MIN_C;  // bench keeps the minimum dominant
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wd_pulse();
    @(negedge clk); wd_n = 1'b0;
    wait_cyc(3);    wd_n = 1'b1;
    wait_cyc(5);
  endtask

  task automatic sw_reset(input logic [31:0] d, input bit extra_wr,
                          output int sys_len, output int mem_len);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d | 32'h1;
    @(negedge clk);
    reg_wr = 1'b0;
    sys_len = 0; mem_len = 0;
    while (!sys_rst_n && sys_len < 5000) begin
      sys_len++;
      if (!mem_rst_n) mem_len++;
      if (extra_wr && sys_len == 20) begin reg_wr = 1'b1; reg_wdata = 32'h1; end
      else reg_wr = 1'b0;
      @(negedge clk);
    end
    reg_wr = 1'b0;
  endtask

  // R9: the system reset only releases at a rising clock edge
  always @(posedge sys_rst_n) begin
    check(($time % 20) == 10, "R9 release edge", 32'($time % 20), 32'd10);
  end

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cnt, slen, mlen;
    void'($urandom(32'd20240611));

    // power-on
    wait_cyc(30);
    check(!sys_rst_n, "R2 held during power-on", 32'(sys_rst_n), 0);
    check(!mem_rst_n, "R7 mem held during power-on", 32'(mem_rst_n), 0);
    por_n = 1'b1;
    cnt = 0;
    while (!sys_rst_n && cnt < 3000) begin
      cnt++;
      if (mem_rst_n) check(0, "R7 mem follows sys on power-on", 1, 0);
      @(negedge clk);
    end
    check(cnt >= EXT_TICKS * REF_RATIO - 5 && cnt <= EXT_TICKS * REF_RATIO + 15,
          "R2 extension length", cnt, EXT_TICKS * REF_RATIO);
    check(cnt >= MIN_C, "R8 power-on minimum", cnt, MIN_C);
    check(mem_rst_n, "R7 mem released with sys", 32'(mem_rst_n), 1);
    check(reg_rdata == 32'h0, "R11 reset state", reg_rdata, 0);

    // watchdog flag behaviour
    wd_pulse(); wd_exp = 1;
    check(reg_rdata == exp_reg(1, 0), "R5 watchdog sets flag", reg_rdata, exp_reg(1, 0));
    check(sys_rst_n && mem_rst_n, "R5 watchdog causes no reset", {sys_rst_n, mem_rst_n}, 2'b11);
    reg_write(32'hFFFF_FFFE); wait_cyc(1);
    check(reg_rdata == exp_reg(1, 0), "R5 R6 write one keeps flag", reg_rdata, exp_reg(1, 0));
    reg_write(32'h0000_0000); wait_cyc(1); wd_exp = 0;
    check(reg_rdata == exp_reg(0, 0), "R5 write zero clears flag", reg_rdata, exp_reg(0, 0));

    // random register traffic mixed with watchdog pulses
    for (int i = 0; i < 60; i++) begin
      int unsigned r = $urandom % 3;
      logic [31:0] d = $urandom & 32'hFFFF_FFFE;
      if (r == 0) begin
        wd_pulse(); wd_exp = 1;
      end else if (r == 1) begin
        reg_write(d); wait_cyc(1);
        if (!d[2]) wd_exp = 0;
      end else begin
        wait_cyc(2);
      end
      check(reg_rdata == exp_reg(wd_exp, sw_exp), "R6 R5 random register state",
            reg_rdata, exp_reg(wd_exp, sw_exp));
      check(sys_rst_n, "R3 no reset without bit 0", 32'(sys_rst_n), 1);
    end

    // software reset with watchdog flag set beforehand
    wd_pulse(); wd_exp = 1;
    sw_reset(32'h5A5A_5A5C, 1'b0, slen, mlen);
    sw_exp = 1; wd_exp = 0;
    check(slen == exp_sw_len(), "R8 software pulse length", slen, exp_sw_len());
    check(mlen == MEM_C, "R7 software mem pulse", mlen, MEM_C);
    wait_cyc(1);
    check(reg_rdata == exp_reg(0, 1), "R3 R4 R5 after software reset", reg_rdata, exp_reg(0, 1));

    // second request during a running reset must not stretch it
    sw_reset(32'h1, 1'b1, slen, mlen);
    check(slen == exp_sw_len(), "R10 busy write ignored", slen, exp_sw_len());
    check(mlen == MEM_C, "R7 mem pulse on repeat", mlen, MEM_C);
    wait_cyc(1);
    check(reg_rdata == exp_reg(0, 1), "R4 cause flag persists", reg_rdata, exp_reg(0, 1));

    // short power-on glitch with both flags set
    wd_pulse(); wd_exp = 1;
    @(negedge clk); por_n = 1'b0;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!sys_rst_n) cnt++;
    end
    por_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!sys_rst_n) cnt++;
    end
    check(cnt == 0, "R1 glitch gives no reset", cnt, 0);
    check(reg_rdata == exp_reg(1, 1), "R1 glitch keeps flags", reg_rdata, exp_reg(1, 1));

    // a full power-on reset clears both flags
    @(negedge clk); por_n = 1'b0;
    wait_cyc(40);
    check(!sys_rst_n && !mem_rst_n, "R1 long request accepted", {sys_rst_n, mem_rst_n}, 0);
    por_n = 1'b1;
    cnt = 0;
    while (!sys_rst_n && cnt < 3000) begin cnt++; @(negedge clk); end
    check(cnt >= EXT_TICKS * REF_RATIO - 5, "R2 extension after second power-on",
          cnt, EXT_TICKS * REF_RATIO);
    wait_cyc(1);
    check(reg_rdata == 32'h0, "R4 R5 R11 cleared by power-on", reg_rdata, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule